// File: doc/BRIEF.md
# Carrier Phase Offset Counter

This block measures how far a received keyed carrier lags a square reference wave that is aligned with the in-phase sine. It watches a stream of offset-binary carrier samples, where the mid-scale code stands for zero volts, together with the level of the reference wave. A measurement starts on a sample where the carrier crosses zero going upward. It ends on the first later sample where the reference wave falls. The number of sample clocks between those two events is latched as the phase result.

Only cycles with the valid strobe high count as sample clocks. A one-cycle done strobe marks each new result. The result is a coarse phase code. Converting it to degrees, or estimating amplitude, is left to the logic that reads it.

Top module: `phase_offset_counter`

## Requirements
- R1: After reset, `phase_cnt` is 0, `done` is 0, and no measurement is running.
- R2: A measurement starts on a valid sample whose value is at or above the mid code (0x40 for 7-bit samples) when the previous valid sample was below it. The first valid sample after reset never starts a measurement.
- R3: A running measurement stops on a valid sample where `ref_lvl` is 0 and `ref_lvl` was 1 on the previous valid sample. The result is the number of valid samples from the crossing sample to the stopping sample, so a fall on the very next sample gives 1.
- R4: The result saturates at the all-ones count (31 for a 5-bit result) when the reference fall comes 31 or more samples after the crossing.
- R5: `done` is high for exactly the one cycle after the clock edge that takes the stopping sample. `phase_cnt` takes its new value on that same edge and holds at all other times.
- R6: A reference fall while no measurement is running is ignored: `done` stays 0 and `phase_cnt` is unchanged.
- R7: Cycles with `smp_valid` low are ignored. They neither count nor take part in detecting a crossing or a reference edge.
- R8: An upward crossing during a running measurement does not restart it.
- R9: A downward crossing, from at or above mid to below mid, never starts a measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | High on cycles that carry a carrier sample |
| smp | input | SAMPLE_W | Offset-binary carrier sample, mid code is zero |
| ref_lvl | input | 1 | Level of the square reference wave |
| phase_cnt | output | COUNT_W | Latched phase count of the last completed measurement |
| done | output | 1 | One-cycle strobe when `phase_cnt` updates |

## Verification
The bench uses the default widths: 7-bit samples with mid code 0x40 and a 5-bit result. With a 5-bit result, saturation is reached after only 31 samples, so both the exact-limit case and the beyond-limit case fit in short directed runs. The 7-bit samples make the boundary codes 0x3F and 0x40 easy to drive directly. These codes test where the crossing comparison switches.

// File: rtl/phase_offset_counter.sv
module phase_offset_counter #(
  parameter int SAMPLE_W = 7,
  parameter int COUNT_W  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp,
  input  logic                ref_lvl,
  output logic [COUNT_W-1:0]  phase_cnt,
  output logic                done
);
  localparam logic [SAMPLE_W-1:0] MID     = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [COUNT_W-1:0]  CNT_MAX = '1;
  localparam logic [COUNT_W-1:0]  CNT_ONE = COUNT_W'(1);

  logic                have_prev;
  logic                prev_low;
  logic                prev_ref;
  logic                running;
  logic [COUNT_W-1:0]  count;

  wire rise_x   = have_prev && prev_low && (smp >= MID);
  wire ref_fall = prev_ref && !ref_lvl;
  wire stop     = running && ref_fall;
  wire [COUNT_W-1:0] next_cnt = (count == CNT_MAX) ? CNT_MAX : count + CNT_ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_low  <= 1'b0;
      prev_ref  <= 1'b0;
      running   <= 1'b0;
      count     <= '0;
      phase_cnt <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (smp_valid) begin
        have_prev <= 1'b1;
        prev_low  <= (smp < MID);
        prev_ref  <= ref_lvl;
        if (stop) begin
          phase_cnt <= count;
          done      <= 1'b1;
          running   <= 1'b0;
        end else if (running) begin
          count <= next_cnt;
        end else if (rise_x) begin
          running <= 1'b1;
          count   <= CNT_ONE;
        end
      end
    end
  end
endmodule

// File: rtl/phase_offset_counter_chk.sv
module phase_offset_counter_chk #(
  parameter int SAMPLE_W = 7,
  parameter int COUNT_W  = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_valid,
  input logic [SAMPLE_W-1:0] smp,
  input logic                ref_lvl,
  input logic [COUNT_W-1:0]  phase_cnt,
  input logic                done
);
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(phase_cnt));

  a_r3_result_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> phase_cnt != '0);

  a_r7_idle_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !done);

  a_r3_stop_on_ref_low: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ref_lvl) == 1'b0);
endmodule

bind phase_offset_counter phase_offset_counter_chk #(
  .SAMPLE_W(SAMPLE_W), .COUNT_W(COUNT_W)
) i_chk (.*);

// File: tb/test_phase_offset_counter.sv
`timescale 1ns/1ps
module test_phase_offset_counter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       smp_valid;
  logic [6:0] smp;
  logic       ref_lvl;
  logic [4:0] phase_cnt;
  logic       done;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  phase_offset_counter i_phase_offset_counter (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp(smp),
    .ref_lvl(ref_lvl), .phase_cnt(phase_cnt), .done(done)
  );

  // {valid, sample[6:0], ref, exp_done, exp_cnt[4:0]}
  localparam int NV = 19;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 7'h40, 1'b1, 1'b0, 5'd0},  // R2 first sample never starts
    {1'b1, 7'h30, 1'b1, 1'b0, 5'd0},
    {1'b1, 7'h45, 1'b1, 1'b0, 5'd0},  // R2 crossing
    {1'b1, 7'h50, 1'b1, 1'b0, 5'd0},
    {1'b1, 7'h60, 1'b0, 1'b1, 5'd2},  // R3 stop, R5 done
    {1'b1, 7'h50, 1'b0, 1'b0, 5'd2},  // R5 hold
    {1'b1, 7'h3F, 1'b1, 1'b0, 5'd2},
    {1'b1, 7'h2F, 1'b0, 1'b0, 5'd2},  // R6 idle fall
    {1'b1, 7'h40, 1'b1, 1'b0, 5'd2},  // R2 crossing at exactly mid
    {1'b0, 7'h10, 1'b0, 1'b0, 5'd2},  // R7 invalid
    {1'b0, 7'h50, 1'b1, 1'b0, 5'd2},  // R7 invalid
    {1'b1, 7'h20, 1'b1, 1'b0, 5'd2},
    {1'b1, 7'h41, 1'b1, 1'b0, 5'd2},  // R8 crossing while running
    {1'b1, 7'h41, 1'b0, 1'b1, 5'd3},  // R8/R7 count 3
    {1'b1, 7'h7F, 1'b0, 1'b0, 5'd3},
    {1'b1, 7'h00, 1'b1, 1'b0, 5'd3},  // R9 downward crossing
    {1'b1, 7'h3F, 1'b0, 1'b0, 5'd3},  // R9 no run, fall ignored
    {1'b1, 7'h7F, 1'b1, 1'b0, 5'd3},  // R2 start
    {1'b1, 7'h7F, 1'b0, 1'b1, 5'd1}   // R3 minimum result
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [6:0] s, input logic r);
    @(negedge clk);
    smp_valid = v; smp = s; ref_lvl = r;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_valid = 1'b0; smp = '0; ref_lvl = 1'b0;
    @(posedge clk); @(posedge clk);
    #1;
    check(phase_cnt == 0, "R1 cnt", phase_cnt, 0);
    check(done == 0, "R1 done", done, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_len(input int d, input int exp);
    step(1'b1, 7'h20, 1'b1);
    step(1'b1, 7'h60, 1'b1);
    for (int k = 1; k < d; k++) begin
      step(1'b1, 7'h60, 1'b1);
      check(done == 0, "R4 no early done", done, 0);
    end
    step(1'b1, 7'h60, 1'b0);
    check(done == 1, "R4 done", done, 1);
    check(phase_cnt == exp, "R4 count", phase_cnt, exp);
    step(1'b1, 7'h60, 1'b0);
    check(done == 0, "R5 single pulse", done, 0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][14], VEC[i][13:7], VEC[i][6]);
      check(done == VEC[i][5], $sformatf("R5 vec%0d done", i), done, VEC[i][5]);
      check(phase_cnt == VEC[i][4:0], $sformatf("R3 vec%0d cnt", i), phase_cnt, VEC[i][4:0]);
    end

    run_len(30, 30);  // below limit
    run_len(31, 31);  // exactly at limit
    run_len(45, 31);  // R4 saturation

    // R1: reset during a measurement aborts it
    step(1'b1, 7'h20, 1'b1);
    step(1'b1, 7'h60, 1'b1);
    step(1'b1, 7'h60, 1'b1);
    do_reset();
    step(1'b1, 7'h60, 1'b1);
    step(1'b1, 7'h60, 1'b0);
    check(done == 0, "R1 no run after reset", done, 0);
    check(phase_cnt == 0, "R1 cnt after reset", phase_cnt, 0);

    // R7: invalid cycles do not count
    step(1'b1, 7'h20, 1'b1);
    step(1'b1, 7'h60, 1'b1);
    for (int k = 0; k < 5; k++) step(1'b0, 7'h00, 1'b0);
    step(1'b1, 7'h60, 1'b0);
    check(done == 1, "R7 done", done, 1);
    check(phase_cnt == 1, "R7 count", phase_cnt, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule